// File: doc/BRIEF.md
# Multi-mode ADC result readout sequencer

This block is the strobe-driven parallel read port for a six-channel converter. It holds no results of its own. The six 16-bit results (channels A0, A1, B0, B1, C0, C1) arrive as a flattened input vector. One pulse per channel marks a fresh result. A separate ordered buffer presents its oldest entry at the head. A host pulls an active-low read strobe. Each strobe returns one 16-bit word on `dout`, and `dout_oe` marks the word as driven, like a tri-state enable.

A 3-bit select picks the source. Codes 0 to 5 address one channel directly. Code 6 walks through the channels in a fixed round-robin order. Code 7 reads the head of the ordered buffer. Two options change the shape of each result sequence. `byte_mode` splits a result into two byte reads. `tag_en` adds a leading header read that carries the channel number and an unread flag, and it applies only in the round-robin and buffer modes. A result therefore takes one, two or three strobes. The block counts the phases of each sequence, advances the round-robin pointer, pops the buffer and clears the unread flag when the last phase has been read.

The block samples the strobe on `clk`. The configuration (select, byte mode and tag enable) is taken when the strobe falls. The phase counter moves when the strobe rises.

Top module: `adc_readout_seq`

## Requirements
- R1: After reset, `dout_oe`, `dout` and `buf_pop` are 0, all unread flags are clear, and the round-robin pointer is at channel 0 (A0).
- R2: Select codes 0 to 5 return result[sel] as the full 16-bit word in one read, whatever the value of `tag_en`.
- R3: With `byte_mode` high, a result takes two data reads. The first returns bits 7..0 and the second returns bits 15..8, both on `dout[7:0]` with `dout[15:8]` = 0.
- R4: Select code 6 delivers channels in the order 0,1,2,3,4,5 (A0,A1,B0,B1,C0,C1) and then wraps to channel 0.
- R5: With `tag_en` high in mode 6 or 7 and `byte_mode` low, the first read returns 16'h8000 | dv<<3 | chan, and the second read returns the full result.
- R6: With `tag_en` high in mode 6 or 7 and `byte_mode` high, the first read returns {8'h00, dv, chan[2:0], result[3:0]}, followed by the low byte and then the high byte.
- R7: Select code 7 reads `buf_data`, tagged with `buf_chan` and with dv = `buf_valid`. A one-cycle `buf_pop` pulse follows the rise of the last read of the sequence, and no pop follows any other read.
- R8: The round-robin pointer advances only after the last read of a complete sequence.
- R9: A channel's unread flag is set by its `new_res` pulse and cleared when a sequence for that channel completes. If both happen in the same cycle, the set wins. The flag is seen as dv in header reads.
- R10: `dout_oe` rises one cycle after the strobe falls and falls one cycle after it rises. `dout` holds steady while `dout_oe` is high.
- R11: If the select, `byte_mode` or `tag_en` differ at a strobe fall from the values taken at the previous fall, the sequence restarts at its first phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_n | input | 1 | Active-low read strobe |
| sel | input | 3 | Source select: 0-5 direct, 6 round-robin, 7 buffer |
| byte_mode | input | 1 | Split each result into two byte reads |
| tag_en | input | 1 | Add a header read in modes 6 and 7 |
| res_flat | input | 96 | Six results, channel i at bits 16*i+15..16*i |
| new_res | input | 6 | Per-channel fresh-result pulse |
| buf_data | input | 16 | Ordered buffer head result |
| buf_chan | input | 3 | Ordered buffer head channel |
| buf_valid | input | 1 | Ordered buffer head holds data |
| dout | output | 16 | Read data word |
| dout_oe | output | 1 | Read data is driven |
| buf_pop | output | 1 | One-cycle pulse: buffer head fully read |

## Verification
The strobe is sampled on the rising clock edge. A strobe driven low at a falling edge therefore gives a valid word and `dout_oe` after the next rising edge. The bench reads that word at the following falling edge. Releasing the strobe clears `dout_oe` after one rising edge. The pointer, the unread flags and `buf_pop` update at the same edge, so the bench checks them at the falling edge that follows. The driver task holds its own model of the phase, pointer and flags and queues the expected word before each strobe. The monitor pops the queue at the first falling edge where it sees `dout_oe` high.

// File: rtl/adc_rdseq_pkg.sv
package adc_rdseq_pkg;
  localparam int NCH   = 6;
  localparam int CH_W  = 3;
  localparam int RES_W = 16;
  localparam int PH_W  = 2;

  typedef enum logic [1:0] {MD_DIRECT, MD_CYCLE, MD_BUFFER} mode_e;

  function automatic mode_e decode_mode(input logic [CH_W-1:0] s);
    if (s == CH_W'(NCH))          return MD_CYCLE;
    else if (s == CH_W'(NCH + 1)) return MD_BUFFER;
    else                          return MD_DIRECT;
  endfunction

  function automatic logic has_header(input mode_e m, input logic tag);
    return (m != MD_DIRECT) && tag;
  endfunction

  // number of strobes making up one complete result sequence
  function automatic logic [PH_W-1:0] reads_needed(input mode_e m, input logic bm,
                                                   input logic tag);
    logic [PH_W-1:0] n;
    n = bm ? PH_W'(2) : PH_W'(1);
    if (has_header(m, tag)) n = n + PH_W'(1);
    return n;
  endfunction

  function automatic logic [RES_W-1:0] format_word(input mode_e m, input logic bm,
      input logic tag, input logic [PH_W-1:0] ph, input logic dv,
      input logic [CH_W-1:0] ch, input logic [RES_W-1:0] d);
    logic [PH_W-1:0] dp;
    if (has_header(m, tag) && ph == '0) begin
      if (bm) return {8'h00, dv, ch, d[3:0]};
      else    return {1'b1, 11'b0, dv, ch};
    end
    dp = has_header(m, tag) ? ph - PH_W'(1) : ph;
    if (!bm)          return d;
    else if (dp == 0) return {8'h00, d[7:0]};
    else              return {8'h00, d[15:8]};
  endfunction
endpackage

// File: rtl/rdseq_strobe.sv
module rdseq_strobe (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_n,
  output logic rd_fall,
  output logic rd_rise
);
  logic rd_q;
  always_ff @(posedge clk) begin
    if (!rst_n) rd_q <= 1'b1;
    else        rd_q <= rd_n;
  end
  assign rd_fall = rd_q & ~rd_n;
  assign rd_rise = ~rd_q & rd_n;
endmodule

// File: rtl/rdseq_unread.sv
module rdseq_unread #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n) flag_o[g] <= 1'b0;
      else        flag_o[g] <= set_i[g] | (flag_o[g] & ~clr_i[g]);
    end

    // R9: a flag only drops when a completed read clears it with no set pending
    a_r9_flag_clear_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag_o[g]) |-> $past(clr_i[g] && !set_i[g]));
  end
endmodule

// File: rtl/rdseq_select.sv
module rdseq_select
  import adc_rdseq_pkg::*;
(
  input  mode_e                mode,
  input  logic [CH_W-1:0]      sel,
  input  logic [CH_W-1:0]      ptr,
  input  logic [NCH*RES_W-1:0] res_flat,
  input  logic [NCH-1:0]       unread,
  input  logic [RES_W-1:0]     buf_data,
  input  logic [CH_W-1:0]      buf_chan,
  input  logic                 buf_valid,
  output logic [CH_W-1:0]      chan,
  output logic [RES_W-1:0]     data,
  output logic                 dv
);
  logic [RES_W-1:0] res_arr [NCH];
  for (genvar g = 0; g < NCH; g++) begin : g_split
    assign res_arr[g] = res_flat[g*RES_W +: RES_W];
  end

  always_comb begin
    chan = '0;
    data = '0;
    dv   = 1'b0;
    unique case (mode)
      MD_BUFFER: begin
        chan = buf_chan;
        data = buf_data;
        dv   = buf_valid;
      end
      default: begin
        chan = (mode == MD_CYCLE) ? ptr : sel;
        if (int'(chan) < NCH) begin
          data = res_arr[chan];
          dv   = unread[chan];
        end
      end
    endcase
  end
endmodule

// File: rtl/adc_readout_seq.sv
module adc_readout_seq
  import adc_rdseq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rd_n,
  input  logic [2:0]           sel,
  input  logic                 byte_mode,
  input  logic                 tag_en,
  input  logic [NCH*RES_W-1:0] res_flat,
  input  logic [NCH-1:0]       new_res,
  input  logic [RES_W-1:0]     buf_data,
  input  logic [CH_W-1:0]      buf_chan,
  input  logic                 buf_valid,
  output logic [RES_W-1:0]     dout,
  output logic                 dout_oe,
  output logic                 buf_pop
);
  localparam int CFG_W = CH_W + 2;

  logic             rd_fall, rd_rise;
  logic [CFG_W-1:0] cfg_now, cfg_q;
  logic [PH_W-1:0]  phase, ph_use;
  logic [CH_W-1:0]  cyc_ptr, chan_q;
  logic [CH_W-1:0]  src_chan;
  logic [RES_W-1:0] src_data;
  logic             src_dv;
  logic [NCH-1:0]   unread, clr_vec;
  mode_e            mode_now, mode_q;
  logic             seq_done;

  rdseq_strobe u_strobe (
    .clk(clk), .rst_n(rst_n), .rd_n(rd_n), .rd_fall(rd_fall), .rd_rise(rd_rise)
  );

  assign mode_now = decode_mode(sel);
  assign cfg_now  = {sel, byte_mode, tag_en};
  assign ph_use   = (cfg_now != cfg_q) ? '0 : phase;
  assign mode_q   = decode_mode(cfg_q[CFG_W-1 -: CH_W]);

  rdseq_select u_select (
    .mode(mode_now), .sel(sel), .ptr(cyc_ptr), .res_flat(res_flat),
    .unread(unread), .buf_data(buf_data), .buf_chan(buf_chan),
    .buf_valid(buf_valid), .chan(src_chan), .data(src_data), .dv(src_dv)
  );

  // last phase of a sequence ends at the strobe rise
  assign seq_done = rd_rise &&
                    (phase == reads_needed(mode_q, cfg_q[1], cfg_q[0]) - PH_W'(1));

  always_comb begin
    clr_vec = '0;
    if (seq_done && int'(chan_q) < NCH) clr_vec[chan_q] = 1'b1;
  end

  rdseq_unread #(.N(NCH)) u_unread (
    .clk(clk), .rst_n(rst_n), .set_i(new_res), .clr_i(clr_vec), .flag_o(unread)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dout    <= '0;
      dout_oe <= 1'b0;
      cfg_q   <= '0;
      phase   <= '0;
      chan_q  <= '0;
      cyc_ptr <= '0;
      buf_pop <= 1'b0;
    end else begin
      buf_pop <= seq_done && (mode_q == MD_BUFFER);
      if (rd_fall) begin
        dout    <= format_word(mode_now, byte_mode, tag_en, ph_use, src_dv,
                               src_chan, src_data);
        dout_oe <= 1'b1;
        cfg_q   <= cfg_now;
        phase   <= ph_use;
        chan_q  <= src_chan;
      end else if (rd_rise) begin
        dout_oe <= 1'b0;
        if (seq_done) begin
          phase <= '0;
          if (mode_q == MD_CYCLE)
            cyc_ptr <= (int'(cyc_ptr) == NCH-1) ? '0 : cyc_ptr + CH_W'(1);
        end else begin
          phase <= phase + PH_W'(1);
        end
      end
    end
  end

  // R10: output enable follows the strobe with one cycle of delay
  a_r10_oe_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fall |=> dout_oe);
  a_r10_oe_off_rise: assert property (@(posedge clk) disable iff (!rst_n)
    rd_rise |=> !dout_oe);
  // R10: the word is held while it is being driven
  a_r10_dout_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_oe && $past(dout_oe)) |-> $stable(dout));
  // R7: a pop is a single-cycle pulse
  a_r7_pop_single: assert property (@(posedge clk) disable iff (!rst_n)
    buf_pop |=> !buf_pop);
  // R8: the round-robin pointer only moves after a completed sequence
  a_r8_ptr_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_ptr != $past(cyc_ptr)) |-> $past(seq_done && mode_q == MD_CYCLE));
endmodule

// File: tb/test_adc_readout_seq.sv
module test_adc_readout_seq;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        rd_n = 1;
  logic [2:0]  sel = 0;
  logic        byte_mode = 0, tag_en = 0;
  logic [95:0] res_flat;
  logic [5:0]  new_res = 0;
  logic [15:0] buf_data = 0;
  logic [2:0]  buf_chan = 0;
  logic        buf_valid = 0;
  logic [15:0] dout;
  logic        dout_oe, buf_pop;

  int checks = 0, errors = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  // bench model state
  int          m_ptr = 0, m_phase = 0;
  logic [4:0]  m_cfg = 0;
  logic [5:0]  m_unread = 0;
  logic [15:0] res [6];

  always #5 clk = ~clk;

  adc_readout_seq i_adc_readout_seq (
    .clk(clk), .rst_n(rst_n), .rd_n(rd_n), .sel(sel), .byte_mode(byte_mode),
    .tag_en(tag_en), .res_flat(res_flat), .new_res(new_res), .buf_data(buf_data),
    .buf_chan(buf_chan), .buf_valid(buf_valid), .dout(dout), .dout_oe(dout_oe),
    .buf_pop(buf_pop)
  );

  always_comb for (int i = 0; i < 6; i++) res_flat[i*16 +: 16] = res[i];

  task automatic check(string req, logic [15:0] act, logic [15:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // monitor: one comparison per driven word
  logic oe_prev = 0;
  always @(negedge clk) begin
    if (dout_oe && !oe_prev) begin
      if (exp_q.size() == 0) check("R10 unexpected word", dout, 16'hxxxx);
      else check(tag_q.pop_front(), dout, exp_q.pop_front());
    end
    oe_prev = dout_oe;
  end

  // driver: one strobe, expected word pushed from the bench model
  task automatic strobe(input logic [2:0] s, input logic bm, input logic tg,
                        input string req, input logic [5:0] pulse = 0);
    int mode, ch, total, k;
    logic hdr, dv;
    logic [15:0] d, w;
    mode = (s == 6) ? 1 : (s == 7) ? 2 : 0;
    if ({s, bm, tg} != m_cfg) m_phase = 0;
    m_cfg = {s, bm, tg};
    ch = (mode == 0) ? int'(s) : (mode == 1) ? m_ptr : int'(buf_chan);
    d  = (mode == 2) ? buf_data : res[ch];
    dv = (mode == 2) ? buf_valid : m_unread[ch];
    hdr = (mode != 0) && tg;
    total = (bm ? 2 : 1) + (hdr ? 1 : 0);
    if (hdr && m_phase == 0)
      w = bm ? {8'h00, dv, 3'(ch), d[3:0]} : (16'h8000 | (16'(dv) << 3) | 16'(ch));
    else begin
      k = m_phase - (hdr ? 1 : 0);
      w = !bm ? d : (k == 0) ? (d & 16'h00ff) : (d >> 8);
    end
    exp_q.push_back(w);
    tag_q.push_back(req);
    @(negedge clk);
    sel = s; byte_mode = bm; tag_en = tg; rd_n = 0;
    @(negedge clk);
    check("R10 oe after fall", 16'(dout_oe), 16'd1);
    @(negedge clk);
    check("R10 dout held", dout, w);
    rd_n = 1; new_res = pulse;
    @(negedge clk);
    new_res = 0;
    check("R10 oe after rise", 16'(dout_oe), 16'd0);
    if (m_phase == total - 1) begin
      m_phase = 0;
      if (mode == 1) m_ptr = (m_ptr + 1) % 6;
      if (ch < 6) m_unread[ch] = 1'b0;
      check("R7 pop after last read", 16'(buf_pop), 16'(mode == 2));
    end else begin
      m_phase++;
      check("R7 no pop mid sequence", 16'(buf_pop), 16'd0);
    end
    m_unread = m_unread | pulse;
  endtask

  task automatic pulse_new(input logic [5:0] m);
    @(negedge clk); new_res = m;
    @(negedge clk); new_res = 0;
    m_unread = m_unread | m;
  endtask

  initial begin
    for (int i = 0; i < 6; i++) res[i] = 16'h1357 + 16'(i) * 16'h2469;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 oe reset", 16'(dout_oe), 16'd0);
    check("R1 dout reset", dout, 16'd0);
    check("R1 pop reset", 16'(buf_pop), 16'd0);
    // R1 + R4: cycle starts at A0; R9: dv clear after reset
    strobe(3'd6, 1'b0, 1'b1, "R1 R5 header from reset");
    strobe(3'd6, 1'b0, 1'b1, "R5 data word A0");
    pulse_new(6'b111111);
    // R2: direct, tag ignored
    for (int c = 0; c < 6; c++) strobe(3'(c), 1'b0, 1'b1, "R2 direct read");
    // R3: direct byte reads
    strobe(3'd3, 1'b1, 1'b0, "R3 low byte");
    strobe(3'd3, 1'b1, 1'b0, "R3 high byte");
    // R4: round robin wrap
    for (int n = 0; n < 7; n++) strobe(3'd6, 1'b0, 1'b0, "R4 cycle order");
    // R5 + R9: header dv
    pulse_new(6'b000100);
    for (int n = 0; n < 4; n++) strobe(3'd6, 1'b0, 1'b1, "R5 R9 tagged word");
    // R6: three byte reads
    for (int n = 0; n < 6; n++) strobe(3'd6, 1'b1, 1'b1, "R6 tagged bytes");
    // R8 + R11: partial sequence then config change restarts, pointer held
    strobe(3'd6, 1'b1, 1'b1, "R8 partial header");
    strobe(3'd6, 1'b1, 1'b0, "R11 restart low byte");
    strobe(3'd6, 1'b1, 1'b0, "R8 high byte same channel");
    strobe(3'd6, 1'b0, 1'b0, "R8 next channel");
    // R9: set wins over clear on final rise
    pulse_new(6'b000001);
    strobe(3'd0, 1'b0, 1'b0, "R9 read with set", 6'b000001);
    while (m_ptr != 0) strobe(3'd6, 1'b0, 1'b0, "R4 align");
    strobe(3'd6, 1'b0, 1'b1, "R9 dv kept by set");
    strobe(3'd6, 1'b0, 1'b1, "R9 data");
    // R7: buffer mode
    buf_data = 16'hbeef; buf_chan = 3'd4; buf_valid = 1;
    strobe(3'd7, 1'b0, 1'b1, "R7 buffer header");
    strobe(3'd7, 1'b0, 1'b1, "R7 buffer data");
    buf_data = 16'h5a3c; buf_chan = 3'd1;
    strobe(3'd7, 1'b1, 1'b0, "R7 buffer low byte");
    strobe(3'd7, 1'b1, 1'b0, "R7 buffer high byte");
    repeat (3) @(negedge clk);
    check("R10 all words consumed", 16'(exp_q.size()), 16'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R10 watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule